// File: doc/BRIEF.md
# Multidrop Address-Flag Receive Filter

This block sits between a serial receiver and the receive FIFO. It supports 9-bit multidrop addressing. The receiver runs with eight data bits and a parity bit held at 0, so a frame whose ninth bit is 1 shows up as a parity error. That deliberate error is the address flag.

When the block runs with automatic filtering off, every received byte goes to the FIFO. Each flagged byte raises a parity-error pulse, and software uses that pulse to pick out address bytes. When automatic filtering is on, the FIFO write path stays shut until a flagged byte carries the station's own address. After that, the unflagged data bytes that follow are written. The path shuts again on either of two events: a flagged byte with a foreign address, or a close pulse from software.

The control is a three-state machine:
- `GATE_PASS`: automatic filtering is off.
- `GATE_HUNT`: the path is shut and the block looks for a matching address.
- `GATE_OPEN`: the path is open.

It moves between them by five named transitions:
- T_ARM: from PASS to HUNT when `auto_en` is high.
- T_MATCH: from HUNT or PASS to OPEN on a matching flagged byte with `auto_en` high.
- T_MISS: from OPEN to HUNT on a non-matching flagged byte.
- T_CLOSE: from OPEN or HUNT to HUNT on `close_pulse`. This takes priority over T_MATCH.
- T_DISARM: from any state to PASS when `auto_en` is low.

The outputs are registered and appear one cycle after the input strobe.

Top module: `mdf_filter`

## Requirements
- R1: While reset is asserted and right after it, `fifo_we`, `par_err` and `addr_open` are 0.
- R2: With `auto_en` low, every byte strobed by `rx_valid` gives `fifo_we`=1 one cycle later, with `fifo_wdata` equal to that byte. This holds whether or not the byte is flagged.
- R3: `par_err` is 1 for exactly the one cycle after a strobed byte with `rx_flag`=1. This holds in both modes. Otherwise it is 0.
- R4: With `auto_en` high and `addr_open` at 0, unflagged strobed bytes are discarded, so `fifo_we` stays 0. After `auto_en` rises, the path starts shut.
- R5: With `auto_en` high and no `close_pulse`, a flagged byte equal to `local_addr` sets `addr_open` to 1 in the next cycle. The address byte itself is never written.
- R6: While `addr_open` is 1 and `auto_en` is high, each unflagged strobed byte is written one cycle later with its data.
- R7: While open, a flagged byte not equal to `local_addr` clears `addr_open` in the next cycle and is not written.
- R8: `close_pulse` clears `addr_open` in the next cycle, and it wins over a matching address in the same cycle. A data byte strobed in the same cycle as the pulse is judged by the state before the pulse.
- R9: Dropping `auto_en` enables writes for bytes in that same cycle and clears `addr_open` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe for a received byte |
| rx_byte | input | 8 | Received data bits |
| rx_flag | input | 1 | Received ninth (parity) bit; 1 marks an address byte |
| local_addr | input | 8 | Station address |
| auto_en | input | 1 | 1 enables automatic address filtering |
| close_pulse | input | 1 | Software request to shut the path and resume hunting |
| fifo_we | output | 1 | Gated FIFO write enable |
| fifo_wdata | output | 8 | Data for the FIFO write |
| par_err | output | 1 | Parity-error (address flag) pulse |
| addr_open | output | 1 | 1 while a matching address has opened the path |

## Verification
The bench attacks the collision cases:
- A close pulse together with a matching address. A design that ordered these the wrong way would reopen the path.
- A data byte in the same cycle as a close pulse. A design that applied the close early would lose the byte.
- Matching address bytes. A design that leaked them would put addresses into the FIFO.
- `auto_en` dropping while the path is open or shut. A late fall-back would drop bytes that should pass.

Random traffic, biased toward the local address, checks each byte against a bench model of the open/shut flag.

// File: rtl/mdf_pkg.sv
package mdf_pkg;
    typedef enum logic [1:0] {
        GATE_PASS = 2'd0,
        GATE_HUNT = 2'd1,
        GATE_OPEN = 2'd2
    } gate_state_t;
endpackage

// File: rtl/mdf_addr_cmp.sv
module mdf_addr_cmp #(
    parameter int DATA_W = 8
) (
    input  logic              rx_valid,
    input  logic              rx_flag,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic [DATA_W-1:0] local_addr,
    output logic              flag_hit,
    output logic              addr_hit
);
    // A flagged byte is an address byte; it matches when all data bits agree.
    always_comb begin
        flag_hit = rx_valid & rx_flag;
        addr_hit = flag_hit & (rx_byte == local_addr);
    end
endmodule

// File: rtl/mdf_gate_fsm.sv
module mdf_gate_fsm
    import mdf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        auto_en,
    input  logic        close_pulse,
    input  logic        rx_valid,
    input  logic        rx_flag,
    input  logic        flag_hit,
    input  logic        addr_hit,
    output logic        wr_req,
    output logic        gate_open
);
    gate_state_t state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GATE_PASS;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (!auto_en) begin
            state_d = GATE_PASS;                       // T_DISARM
        end else begin
            unique case (state_q)
                GATE_PASS, GATE_HUNT: begin
                    if (close_pulse)   state_d = GATE_HUNT;   // T_CLOSE wins
                    else if (addr_hit) state_d = GATE_OPEN;   // T_MATCH
                    else               state_d = GATE_HUNT;   // T_ARM / stay
                end
                GATE_OPEN: begin
                    if (close_pulse)   state_d = GATE_HUNT;   // T_CLOSE
                    else if (flag_hit && !addr_hit)
                                       state_d = GATE_HUNT;   // T_MISS
                    else               state_d = GATE_OPEN;
                end
                default:               state_d = GATE_HUNT;
            endcase
        end
    end

    // Outputs: decision uses the state before this cycle's events
    always_comb begin
        gate_open = (state_q == GATE_OPEN);
        wr_req    = 1'b0;
        if (rx_valid) begin
            if (!auto_en)       wr_req = 1'b1;
            else if (gate_open) wr_req = !rx_flag;
        end
    end
endmodule

// File: rtl/mdf_out_stage.sv
module mdf_out_stage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              flag_hit,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              fifo_we,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              par_err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_we    <= 1'b0;
            fifo_wdata <= '0;
            par_err    <= 1'b0;
        end else begin
            fifo_we <= wr_req;
            par_err <= flag_hit;
            if (wr_req) fifo_wdata <= rx_byte;
        end
    end
endmodule

// File: rtl/mdf_filter.sv
module mdf_filter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_flag,
    input  logic [DATA_W-1:0] local_addr,
    input  logic              auto_en,
    input  logic              close_pulse,
    output logic              fifo_we,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              par_err,
    output logic              addr_open
);
    logic flag_hit, addr_hit, wr_req;

    mdf_addr_cmp #(.DATA_W(DATA_W)) cmp_i (
        .rx_valid   (rx_valid),
        .rx_flag    (rx_flag),
        .rx_byte    (rx_byte),
        .local_addr (local_addr),
        .flag_hit   (flag_hit),
        .addr_hit   (addr_hit)
    );

    mdf_gate_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .auto_en     (auto_en),
        .close_pulse (close_pulse),
        .rx_valid    (rx_valid),
        .rx_flag     (rx_flag),
        .flag_hit    (flag_hit),
        .addr_hit    (addr_hit),
        .wr_req      (wr_req),
        .gate_open   (addr_open)
    );

    mdf_out_stage #(.DATA_W(DATA_W)) out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (wr_req),
        .flag_hit   (flag_hit),
        .rx_byte    (rx_byte),
        .fifo_we    (fifo_we),
        .fifo_wdata (fifo_wdata),
        .par_err    (par_err)
    );
endmodule

// File: rtl/mdf_filter_chk.sv
module mdf_filter_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_flag,
    input logic [DATA_W-1:0] local_addr,
    input logic              auto_en,
    input logic              close_pulse,
    input logic              fifo_we,
    input logic              par_err,
    input logic              addr_open
);
    // R3
    flag_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_flag) |=> par_err);
    // R3
    noflag_perr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_flag) |=> !par_err);
    // R2
    pass_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && rx_valid) |=> fifo_we);
    // R5
    addr_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && rx_valid && rx_flag) |=> !fifo_we);
    // R4
    hunt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !addr_open) |=> !fifo_we);
    // R5
    match_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && !close_pulse && rx_valid && rx_flag && rx_byte == local_addr)
        |=> addr_open);
    // R8
    close_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        close_pulse |=> !addr_open);
    // R9
    disarm_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> !addr_open);
endmodule

bind mdf_filter mdf_filter_chk #(.DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_byte     (rx_byte),
    .rx_flag     (rx_flag),
    .local_addr  (local_addr),
    .auto_en     (auto_en),
    .close_pulse (close_pulse),
    .fifo_we     (fifo_we),
    .par_err     (par_err),
    .addr_open   (addr_open)
);

// File: tb/mdf_filter_tb.sv
module mdf_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_flag = 1'b0;
    logic [7:0] local_addr = 8'h5A;
    logic       auto_en = 1'b0;
    logic       close_pulse = 1'b0;
    logic       fifo_we;
    logic [7:0] fifo_wdata;
    logic       par_err;
    logic       addr_open;

    int total = 0;
    int bad = 0;
    bit open_m = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    mdf_filter #(.DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_flag(rx_flag), .local_addr(local_addr), .auto_en(auto_en),
        .close_pulse(close_pulse), .fifo_we(fifo_we), .fifo_wdata(fifo_wdata),
        .par_err(par_err), .addr_open(addr_open)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_we(bit v, bit f, bit a, bit o);
        return v && (!a || (o && !f));
    endfunction

    function automatic bit exp_open(bit v, bit f, bit m, bit a, bit c, bit o);
        if (!a) return 1'b0;
        if (c) return 1'b0;
        if (v && f) return m;
        return o;
    endfunction

    // One cycle: drive at negedge, sample 1 ns after the next posedge.
    task automatic step(bit v, bit f, logic [7:0] b, bit a, bit c);
        bit we_e, op_e, m;
        string t_we, t_op;
        @(negedge clk);
        rx_valid = v; rx_flag = f; rx_byte = b; auto_en = a; close_pulse = c;
        m    = (b == local_addr);
        we_e = exp_we(v, f, a, open_m);
        op_e = exp_open(v, f, m, a, c, open_m);
        if (!a)          t_we = "R2";
        else if (v && f) t_we = "R5";
        else if (open_m) t_we = c ? "R8" : "R6";
        else             t_we = "R4";
        if (!a)              t_op = "R9";
        else if (c)          t_op = "R8";
        else if (v && f && m) t_op = "R5";
        else if (v && f)     t_op = "R7";
        else                 t_op = open_m ? "R6" : "R4";
        @(posedge clk); #1;
        chk(t_we, int'(fifo_we), int'(we_e));
        if (we_e) chk(t_we, int'(fifo_wdata), int'(b));
        chk("R3", int'(par_err), int'(v && f));
        chk(t_op, int'(addr_open), int'(op_e));
        open_m = op_e;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'h1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values
        chk("R1", int'(fifo_we), 0);
        chk("R1", int'(par_err), 0);
        chk("R1", int'(addr_open), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1", int'(addr_open), 0);

        // R2/R3 software mode: all bytes pass, flag marks address
        step(1, 0, 8'h11, 0, 0);
        step(1, 1, 8'h5A, 0, 0);
        step(0, 0, 8'h00, 0, 0);
        // R4: arm, data dropped
        step(1, 0, 8'h22, 1, 0);
        step(1, 0, 8'h23, 1, 0);
        step(1, 1, 8'h33, 1, 0);   // non-matching address while hunting
        // R5: matching address opens, not written
        step(1, 1, 8'h5A, 1, 0);
        // R6: data written
        step(1, 0, 8'hA1, 1, 0);
        step(1, 0, 8'hA2, 1, 0);
        step(1, 1, 8'h5A, 1, 0);   // re-match stays open
        // R7: foreign address closes
        step(1, 1, 8'h77, 1, 0);
        step(1, 0, 8'hA3, 1, 0);
        // R8: data in close cycle still written, then shut
        step(1, 1, 8'h5A, 1, 0);
        step(1, 0, 8'hB1, 1, 1);
        step(1, 0, 8'hB2, 1, 0);
        // R8: close beats matching address
        step(1, 1, 8'h5A, 1, 1);
        step(1, 0, 8'hB3, 1, 0);
        // R9: drop auto while open: same-cycle byte written
        step(1, 1, 8'h5A, 1, 0);
        step(1, 0, 8'hC1, 0, 0);
        step(1, 1, 8'hC2, 0, 0);
        // R9: drop auto while hunting
        step(1, 0, 8'hC3, 1, 0);
        step(1, 0, 8'hC4, 0, 0);

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            bit a, v, f, c;
            logic [7:0] b;
            a = ($urandom % 16) != 0;
            v = ($urandom % 4) != 0;
            f = ($urandom % 4) == 0;
            c = ($urandom % 20) == 0;
            b = (($urandom % 2) == 0) ? local_addr : 8'($urandom);
            step(v, f, b, a, c);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule